// File: doc/BRIEF.md
# External Interrupt Flag and Wake Unit

This block watches four external interrupt pins. Each pin is brought into the clock domain by a synchroniser. Each channel is then checked either for a level or for one edge direction, as its mode and polarity settings choose. A detected condition sets a sticky flag for that channel. The flag drives the channel's interrupt request line. It also drives the channel's wake request line when the channel's wake enable is set. Software reads the flags through a small word-indexed register port and clears them by writing ones.

In level mode the pin keeps setting its flag while it stays active. A clear therefore only takes hold once the pin has returned to its inactive level. Changing mode or polarity leaves the flags as they are. Software is expected to clear them after any reconfiguration.

On the first settled sample after reset, the block also records whether channel 1 is being held low. It reports that state as a boot request until the next reset.

Top module: `ext_irq_unit`

## Requirements
- R1: A pin change that meets a channel's set condition shows on `irq_o` after the third rising clock edge that follows it: two synchroniser stages, then the flag. No flag can set during the first three clock edges after reset is released.
- R2: With the mode bit at 1 (edge mode), only the transition that polarity selects sets the flag: polarity 1 selects rising and polarity 0 selects falling. The opposite transition leaves the flag unchanged.
- R3: Flags are sticky. A write to word index 0 clears every flag whose write-data bit is 1. Bits written as 0 leave their flags unchanged. No other event clears a flag.
- R4: Word indices 0, 1, 2 and 3 (byte offsets 0x0, 0x4, 0x8, 0xC) select the flag, wake-enable, mode and polarity registers, with bit i belonging to channel i. All four reset to 0. A read returns the current contents of the selected register.
- R5: With the mode bit at 0 (level mode), the flag sets while the synchronised pin equals the polarity bit: 1 means active high, 0 means active low. A clear written while the pin is still active has no effect. A clear written while the pin is inactive takes effect.
- R6: `wake_o[i]` is high exactly when channel i's flag and its wake-enable bit are both set.
- R7: `boot_req_o` is 1 when channel 1's synchronised pin is low at the first settled sample after reset. It then holds that value until the next reset, whatever the pin does afterwards.
- R8: Writing the mode or polarity register does not clear any flag.
- R9: Channels are independent. An event on one channel sets only that channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_CH | Raw external interrupt pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word index |
| reg_wdata_i | input | NUM_CH | Register write data |
| reg_rdata_o | output | NUM_CH | Read data of the selected register |
| irq_o | output | NUM_CH | Interrupt request per channel (flag state) |
| wake_o | output | NUM_CH | Wake request per channel |
| boot_req_o | output | 1 | Channel 1 held low at reset exit |

## Verification
The bench uses the default build: four channels and two synchroniser stages. With these values the three-edge latency of R1 can be counted exactly. Each of the four mode and polarity combinations can be placed on its own channel, so one channel's flag can be checked while the others stay quiet. Two synchroniser stages also keep the boot sample close to reset exit, so a second reset with channel 1 held low reaches R7 within a few cycles.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_IDX_W = 2;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_FLAG = 2'd0,
    REG_WAKE = 2'd1,
    REG_MODE = 2'd2,
    REG_POL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic settled_i,
  input  logic pin_s_i,
  input  logic edge_mode_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q, flag_q;
  logic active, edge_hit, set;

  assign active   = (pin_s_i == pol_i);
  assign edge_hit = active && (pin_s_i != prev_q);
  assign set      = settled_i && (edge_mode_i ? edge_hit : active);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      // set dominates: a level clear while active is lost
      flag_q <= set | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [REG_IDX_W-1:0] addr_i,
  input  logic [NUM_CH-1:0]    wdata_i,
  input  logic [NUM_CH-1:0]    flag_i,
  output logic [NUM_CH-1:0]    wake_en_o,
  output logic [NUM_CH-1:0]    mode_o,
  output logic [NUM_CH-1:0]    pol_o,
  output logic [NUM_CH-1:0]    clr_o,
  output logic [NUM_CH-1:0]    rdata_o
);
  reg_sel_e sel;
  logic [NUM_CH-1:0] wake_q, mode_q, pol_q;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else if (we_i) begin
      case (sel)
        REG_WAKE: wake_q <= wdata_i;
        REG_MODE: mode_q <= wdata_i;
        REG_POL:  pol_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign clr_o = (we_i && sel == REG_FLAG) ? wdata_i : '0;

  always_comb begin
    case (sel)
      REG_FLAG: rdata_o = flag_i;
      REG_WAKE: rdata_o = wake_q;
      REG_MODE: rdata_o = mode_q;
      default:  rdata_o = pol_q;
    endcase
  end

  assign wake_en_o = wake_q;
  assign mode_o    = mode_q;
  assign pol_o     = pol_q;
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int BOOT_CH     = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    pin_i,
  input  logic                 reg_we_i,
  input  logic [REG_IDX_W-1:0] reg_addr_i,
  input  logic [NUM_CH-1:0]    reg_wdata_i,
  output logic [NUM_CH-1:0]    reg_rdata_o,
  output logic [NUM_CH-1:0]    irq_o,
  output logic [NUM_CH-1:0]    wake_o,
  output logic                 boot_req_o
);
  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(SETTLE + 1);

  logic [NUM_CH-1:0] pin_s, flags, wake_en, mode, pol, clr;
  logic [CNT_W-1:0]  settle_q;
  logic              settled, boot_q;

  ext_irq_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  // settled once the chain and the edge history hold real samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q <= '0;
      boot_q   <= 1'b0;
    end else if (!settled) begin
      settle_q <= settle_q + 1'b1;
      if (settle_q == CNT_W'(SYNC_STAGES)) boot_q <= ~pin_s[BOOT_CH];
    end
  end

  assign settled = (settle_q == CNT_W'(SETTLE));

  ext_irq_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .flag_i   (flags),
    .wake_en_o(wake_en),
    .mode_o   (mode),
    .pol_o    (pol),
    .clr_o    (clr),
    .rdata_o  (reg_rdata_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ext_irq_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .settled_i  (settled),
      .pin_s_i    (pin_s[i]),
      .edge_mode_i(mode[i]),
      .pol_i      (pol[i]),
      .clr_i      (clr[i]),
      .flag_o     (flags[i])
    );
  end

  assign irq_o      = flags;
  assign wake_o     = flags & wake_en;
  assign boot_req_o = boot_q;
endmodule

// File: rtl/ext_irq_unit_chk.sv
module ext_irq_unit_chk #(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [NUM_CH-1:0] reg_wdata_i,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] wake_o,
  input logic              boot_req_o
);
  localparam int LIM = SYNC_STAGES + 2;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0]     cyc_q;
  logic [NUM_CH-1:0] clr_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      clr_q <= '0;
      irq_q <= '0;
    end else begin
      if (cyc_q != CW'(LIM)) cyc_q <= cyc_q + 1'b1;
      clr_q <= (reg_we_i && reg_addr_i == 2'd0) ? reg_wdata_i : '0;
      irq_q <= irq_o;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_q & ~irq_o & ~clr_q) == '0)); // R3

  AST_WAKE_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wake_o & ~irq_o) == '0)); // R6

  AST_NO_EARLY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q <= CW'(SYNC_STAGES + 1)) |-> (irq_o == '0)); // R1

  AST_BOOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CW'(LIM)) |-> $stable(boot_req_o)); // R7
endmodule

bind ext_irq_unit ext_irq_unit_chk #(
  .NUM_CH     (NUM_CH),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_o      (irq_o),
  .wake_o     (wake_o),
  .boot_req_o (boot_req_o)
);

// File: tb/ext_irq_unit_tb.sv
module ext_irq_unit_tb;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin = '1;
  logic           we = 1'b0;
  logic [1:0]     addr = '0;
  logic [NCH-1:0] wdata = '0;
  logic [NCH-1:0] rdata, irq, wake;
  logic           boot;

  int total = 0, bad = 0;
  bit done = 0;

  // scoreboard: kind 0=irq 1=wake 2=boot 3=rdata
  int             kind_q[$];
  logic [NCH-1:0] exp_q[$];
  string          tag_q[$];
  event           chk_ev;

  always #10 clk = ~clk;

  ext_irq_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .wake_o(wake), .boot_req_o(boot)
  );

  initial begin
    forever begin
      @(chk_ev);
      while (kind_q.size() > 0) begin
        automatic int k = kind_q.pop_front();
        automatic logic [NCH-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        automatic logic [NCH-1:0] a;
        case (k)
          0: a = irq;
          1: a = wake;
          2: a = {{(NCH-1){1'b0}}, boot};
          default: a = rdata;
        endcase
        total++;
        if (a !== e) begin
          bad++;
          $display("FAIL %s: actual=%b expected=%b", t, a, e);
        end
      end
    end
  end

  task automatic expect_obs(input int k, input logic [NCH-1:0] e, input string t);
    kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
    #1; -> chk_ev; #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [NCH-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [NCH-1:0] e, input string t);
    @(negedge clk); addr = a;
    expect_obs(3, e, t);
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk); pin[i] = v;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R4 reset values
    rd(2'd0, 4'h0, "R4 flag reset");
    rd(2'd1, 4'h0, "R4 wake reset");
    rd(2'd2, 4'h0, "R4 mode reset");
    rd(2'd3, 4'h0, "R4 pol reset");
    expect_obs(0, 4'h0, "R4 irq reset");
    expect_obs(2, 4'h0, "R7 boot clear with pin1 high");

    // ch0 rising edge, ch3 falling edge
    wr(2'd2, 4'b1001);
    wr(2'd3, 4'b0001);
    rd(2'd2, 4'b1001, "R4 mode readback");
    set_pin(0, 1'b0); cyc(3);
    expect_obs(0, 4'h0, "R2 falling ignored in rising mode");
    set_pin(0, 1'b1); cyc(2);
    expect_obs(0, 4'h0, "R1 not yet after two edges");
    cyc(1);
    expect_obs(0, 4'b0001, "R1 R2 rising sets flag");

    wr(2'd0, 4'b1110);
    expect_obs(0, 4'b0001, "R3 zero bit leaves flag");
    wr(2'd0, 4'b0001);
    expect_obs(0, 4'b0000, "R3 write one clears");
    rd(2'd0, 4'h0, "R3 flag reg cleared");

    // wake
    wr(2'd1, 4'b0001);
    expect_obs(1, 4'b0000, "R6 no wake without flag");
    set_pin(0, 1'b0); cyc(1); set_pin(0, 1'b1); cyc(3);
    expect_obs(1, 4'b0001, "R6 wake with flag and enable");
    wr(2'd1, 4'b0000);
    expect_obs(1, 4'b0000, "R6 wake off when disabled");
    expect_obs(0, 4'b0001, "R6 flag kept");
    wr(2'd0, 4'b0001);

    // ch2 level: active low by default
    set_pin(2, 1'b0); cyc(3);
    expect_obs(0, 4'b0100, "R5 R9 level low sets ch2 only");
    wr(2'd3, 4'b0101);
    expect_obs(0, 4'b0100, "R8 polarity write keeps flag");
    wr(2'd0, 4'b0100);
    expect_obs(0, 4'b0000, "R5 clear while inactive");
    set_pin(2, 1'b1); cyc(3);
    expect_obs(0, 4'b0100, "R5 level high sets");
    wr(2'd0, 4'b0100);
    expect_obs(0, 4'b0100, "R5 clear while active ignored");
    rd(2'd0, 4'b0100, "R4 flag reg readback");
    set_pin(2, 1'b0); cyc(3);
    expect_obs(0, 4'b0100, "R3 flag sticky after pin inactive");
    wr(2'd0, 4'b0100);
    expect_obs(0, 4'b0000, "R5 clear after release");

    // ch3 falling edge
    set_pin(3, 1'b0); cyc(3);
    expect_obs(0, 4'b1000, "R2 R9 falling sets ch3 only");
    wr(2'd3, 4'b1101);
    expect_obs(0, 4'b1000, "R8 polarity change keeps edge flag");
    wr(2'd2, 4'b0001);
    expect_obs(0, 4'b1000, "R8 mode change keeps flag");
    wr(2'd2, 4'b1001);
    wr(2'd0, 4'b1000);
    expect_obs(0, 4'b0000, "R3 ch3 cleared");
    set_pin(3, 1'b1); cyc(3);
    expect_obs(0, 4'b1000, "R2 rising after polarity change");
    wr(2'd0, 4'b1000);

    // boot request
    pin[1] = 1'b0;
    do_reset();
    expect_obs(2, 4'b0001, "R7 boot with pin1 low");
    set_pin(1, 1'b1); cyc(4);
    expect_obs(2, 4'b0001, "R7 boot held after release");
    rd(2'd3, 4'h0, "R4 pol reset again");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule